// File: doc/BRIEF.md
# System Counter Compare Event Unit

This block keeps a free-running system counter beside a single compare target. When the counter value is exactly equal to the target, a sticky event flag is raised. A processor issues operations on a plain strobe interface. It can read the counter to take a reference time and add a delta to the target to schedule the next event. It can also test the flag, either by polling it into a carry bit or by deciding a conditional jump on it. A typical use is a periodic wake-up: read the counter once, then keep adding the period to the target and testing for the event.

Every operation takes two clocks. On the first clock the operation is accepted and its results are registered. During the second clock `done` is high and no new operation is accepted. A flag test reads the flag and clears it on the same first clock. A compare match that lands on that same clock therefore survives and is reported by the next test. This design never loses an event and does not leave one waiting until the next counter wrap.

Operation codes on `op_code`: 0 no-op, 1 read counter, 2 add to target, 3 poll, 4 jump-if-set, 5 jump-if-clear. Codes 6 and 7 behave as no-ops.

Top module: `sysctr_event_unit`

## Requirements
- R1: After reset the counter, the target and the flag are zero, and `rd_data`, `result_carry`, `jump_taken` and `done` read 0.
- R2: The counter increments by one on every clock and wraps modulo 2^CNT_W. A read-counter operation (code 1) loads `rd_data` with the counter value held on the accepting clock.
- R3: An add-to-target operation (code 2) replaces the target with target + `op_delta`, modulo 2^CNT_W. Any other operation leaves the target unchanged.
- R4: The flag is set on any clock where the counter equals the target on all CNT_W bits. Once set, it stays set until a flag test clears it.
- R5: A poll (code 3) loads `result_carry` with the flag value from the accepting clock and clears the flag on that same clock.
- R6: When a match and a flag test fall on the same clock, the flag stays set. The test reports the flag value from before that clock, and the next test reports 1.
- R7: Jump-if-set (code 4) drives `jump_taken` to the sampled flag value, and jump-if-clear (code 5) drives it to the inverse of that value. Both also load `result_carry` with the sample and clear the flag on the accepting clock. Codes other than 4 and 5 give `jump_taken` = 0.
- R8: When `op_go` is high and `done` is low on a clock, the operation is accepted. Its results appear after that edge, and `done` is then high for exactly one clock. An `op_go` raised while `done` is high is ignored and changes no output.
- R9: A target that the counter has already passed raises no event until the counter wraps around to it.
- R10: Each compare match is reported as a 1 sample by exactly one flag test, no more and no fewer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_go | input | 1 | Operation strobe, accepted when `done` is low |
| op_code | input | 3 | Operation code (see above) |
| op_delta | input | CNT_W | Delta for add-to-target |
| rd_data | output | CNT_W | Counter value captured by read-counter |
| result_carry | output | 1 | Flag sample from the last test operation |
| jump_taken | output | 1 | Jump decision from the last jump operation |
| done | output | 1 | High during the second clock of an operation |

## Verification
The bench builds the unit with CNT_W = 6, so the counter wraps every 64 clocks. That short wrap lets the bench schedule targets at every phase against test issue and reach past-target and wrap cases within a few hundred clocks. An arithmetic reference model tracks the counter, target and flag. Test operations are issued at each offset around the match clock, including exactly on it, and the bench checks every sample and confirms that the count of matches equals the count of reported events.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_GETCNT = 3'd1,
    OP_ADDTGT = 3'd2,
    OP_POLL   = 3'd3,
    OP_JSET   = 3'd4,
    OP_JCLR   = 3'd5
  } op_e;
endpackage

// File: rtl/sysctr_counter.sv
module sysctr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CNT_W'(1);
  end

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/sysctr_target.sv
module sysctr_target #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CNT_W-1:0] delta,
  input  logic [CNT_W-1:0] cnt,
  output logic             match
);
  logic [CNT_W-1:0] tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt <= '0;
    else if (add_en) tgt <= tgt + delta;
  end

  assign match = (cnt == tgt);

  p_tgt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(tgt));
  p_tgt_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> tgt == CNT_W'($past(tgt) + $past(delta)));
endmodule

// File: rtl/sysctr_flag.sv
module sysctr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // Set dominates a clear on the same clock; the reader samples the pre-edge value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/sysctr_event_unit.sv
module sysctr_event_unit
  import sysctr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_go,
  input  logic [2:0]       op_code,
  input  logic [CNT_W-1:0] op_delta,
  output logic [CNT_W-1:0] rd_data,
  output logic             result_carry,
  output logic             jump_taken,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic             match, flag, accept;
  logic             is_get, is_add, is_poll, is_jset, is_jclr, is_test;

  assign accept  = op_go && !done;
  assign is_get  = accept && (op_code == OP_GETCNT);
  assign is_add  = accept && (op_code == OP_ADDTGT);
  assign is_poll = accept && (op_code == OP_POLL);
  assign is_jset = accept && (op_code == OP_JSET);
  assign is_jclr = accept && (op_code == OP_JCLR);
  assign is_test = is_poll || is_jset || is_jclr;

  sysctr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt)
  );

  sysctr_target #(.CNT_W(CNT_W)) u_tgt (
    .clk(clk), .rst_n(rst_n), .add_en(is_add), .delta(op_delta),
    .cnt(cnt), .match(match)
  );

  sysctr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(match), .clr(is_test), .flag(flag)
  );

  // Sample and clear both happen on the accepting (first) clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      result_carry <= 1'b0;
      jump_taken   <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= accept;
      if (is_get)  rd_data <= cnt;
      if (is_test) result_carry <= flag;
      if (accept)  jump_taken <= (is_jset && flag) || (is_jclr && !flag);
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(rd_data) && $stable(result_carry) && $stable(jump_taken)));
  p_test_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_test |=> result_carry == $past(flag));
endmodule

// File: tb/test_sysctr_event_unit.sv
module test_sysctr_event_unit;
  localparam int W = 6;
  localparam int CLK_PERIOD = 10;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_go = 1'b0;
  logic [2:0] op_code = '0;
  logic [W-1:0] op_delta = '0;
  logic [W-1:0] rd_data;
  logic result_carry, jump_taken, done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctr_event_unit #(.CNT_W(W)) i_sysctr_event_unit (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_code),
    .op_delta(op_delta), .rd_data(rd_data), .result_carry(result_carry),
    .jump_taken(jump_taken), .done(done)
  );

  // Arithmetic reference model built from the requirements.
  int m_cnt = 0, m_tgt = 0;
  bit m_flag = 0, m_busy = 0;
  int e_rd = 0;
  bit e_carry = 0, e_jump = 0;
  int n_match = 0, n_report = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_tgt = 0; m_flag = 0; m_busy = 0;
      e_rd = 0; e_carry = 0; e_jump = 0;
    end else begin
      bit acc, tst, mt;
      acc = op_go && !m_busy;
      mt  = (m_cnt == m_tgt);
      tst = acc && (op_code == 3 || op_code == 4 || op_code == 5);
      if (mt) n_match++;
      if (acc && op_code == 1) e_rd = m_cnt;
      if (tst) begin
        e_carry = m_flag;
        if (m_flag) n_report++;
      end
      if (acc) e_jump = (op_code == 4 && m_flag) || (op_code == 5 && !m_flag);
      if (acc && op_code == 2) m_tgt = (m_tgt + int'(op_delta)) % MOD;
      m_flag = mt || (m_flag && !tst);
      m_cnt  = (m_cnt + 1) % MOD;
      m_busy = acc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one operation and check its results during the second clock.
  task automatic issue(input int code, input int delta, input string req);
    @(negedge clk);
    op_go = 1'b1; op_code = 3'(code); op_delta = W'(delta);
    @(negedge clk);
    op_go = 1'b0;
    chk({req, " done"}, int'(done), 1);
    if (code == 1) chk({req, " rd"}, int'(rd_data), e_rd);
    if (code >= 3 && code <= 5) chk({req, " carry"}, int'(result_carry), int'(e_carry));
    chk({req, " jump"}, int'(jump_taken), int'(e_jump));
  endtask

  task automatic wait_cnt(input int value);
    while (m_cnt != value) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd", int'(rd_data), 0);
    chk("R1 carry", int'(result_carry), 0);
    chk("R1 jump", int'(jump_taken), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Target 0 matched at first clock: drain it.
    issue(3, 0, "R4 poll after reset");

    // R2: read counter across a wrap
    for (int i = 0; i < 40; i++) issue(1, 0, "R2 getcnt");

    // R8: op_go while done is high is ignored
    @(negedge clk); op_go = 1'b1; op_code = 3'd1;
    @(negedge clk); op_code = 3'd3;
    begin
      int rd_keep; rd_keep = int'(rd_data);
      @(negedge clk); op_go = 1'b0;
      chk("R8 done drops", int'(done), 0);
      chk("R8 ignored rd", int'(rd_data), rd_keep);
    end

    // R5/R7/R10: sweep test phase around each match, rotating the test kind
    for (int d = 5; d < 45; d += 7) begin
      for (int ph = 0; ph < 8; ph++) begin
        int kind; kind = 3 + ((d + ph) % 3);
        issue(2, d, "R3 add");
        repeat (ph) @(negedge clk);
        for (int k = 0; k < 6; k++) issue(kind, 0, "R7 test sweep");
        issue(3, 0, "R5 poll sweep");
      end
    end

    // R6: test on the exact match clock
    wait_cnt(10);
    issue(2, (m_tgt + MOD + 30 - m_tgt) % MOD == 0 ? 1 : (30 - m_tgt + MOD) % MOD, "R3 add to 30");
    issue(3, 0, "R6 clear before");
    wait_cnt(30);
    op_go = 1'b1; op_code = 3'd3;
    @(negedge clk); op_go = 1'b0;
    chk("R6 same-clock sample", int'(result_carry), 0);
    issue(3, 0, "R6 next poll");
    chk("R6 next poll reports", int'(result_carry), 1);

    // R9: target behind counter raises nothing until wrap
    wait_cnt(40);
    issue(2, MOD - 5, "R3 add behind");  // target 25, counter past it
    issue(3, 0, "R9 early poll");
    chk("R9 no event yet", int'(result_carry), 0);
    wait_cnt(20);
    issue(3, 0, "R9 before wrap target");
    chk("R9 still none", int'(result_carry), 0);
    wait_cnt(27);
    issue(3, 0, "R9 after wrap");
    chk("R9 event after wrap", int'(result_carry), 1);

    // R10: drain and compare matches with reports
    repeat (2) issue(3, 0, "R10 drain");
    chk("R10 matches reported once", n_report, n_match);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule